// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block translates a 48-bit virtual address into a 52-bit physical address. It does this by walking a four-level radix page table kept in memory. A request carries the virtual address and an access type (load or store). The walker reads one 8-byte entry per level through a simple memory read port, starting at the table named by a root register. It answers with either the physical address or a fault code together with the level at which the walk stopped.

The root register holds the physical page number of the top-level table. Software loads it through a separate configuration write, so one root can be replaced by another between translations. Only one translation is in flight at a time. Pages are 4 KiB, and there is no translation caching, large-page support or entry update.

Top module: `ptw_walker`

## Requirements
- R1: On a successful translation, `rsp_paddr[11:0]` equals `req_vaddr[11:0]`, and `rsp_paddr[51:12]` is the page number taken from the leaf entry.
- R2: Level 3 (root) indexes with `vaddr[47:39]`, level 2 with `vaddr[38:30]`, level 1 with `vaddr[29:21]` and level 0 (leaf) with `vaddr[20:12]`. Each entry address is the table page number times 4096 plus the index times 8, so the address is always 8-byte aligned.
- R3: A walk that finds no invalid entry issues exactly four reads, in order from level 3 to level 0. Each following table base is bits 51:12 of the entry read just before it.
- R4: An entry uses bit 0 as present, bit 1 as writable and bits 51:12 as page number. Bits 63:52 and 11:2 have no effect on the result.
- R5: A non-present entry at any level ends the walk at once, with no further reads. The result is `rsp_fault` = 2'b01, `rsp_level` = that level (3 = root … 0 = leaf) and `rsp_paddr` = 0.
- R6: A store whose leaf entry has bit 1 clear gives `rsp_fault` = 2'b10 at level 0, while a load through the same entry succeeds. The writable bit of non-leaf entries is ignored.
- R7: `req_ready` is high only while no walk is in progress. `rsp_valid` is a one-cycle pulse with `rsp_fault` = 2'b00 on success, and `req_ready` is high again in the cycle after that pulse.
- R8: A walk uses the root value current when its request is accepted. A configuration write in the same cycle as acceptance applies to that walk, and a write during a walk affects only later walks.
- R9: `mem_req_valid` stays high with a stable `mem_req_addr` until `mem_req_ready` is seen. The entry data is taken from the first `mem_rsp_valid` after that, whatever the latency.
- R10: After reset, `req_ready` = 1, `rsp_valid` = 0, `mem_req_valid` = 0 and the root page number is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_root_we | input | 1 | Load the root register |
| cfg_root_ppn | input | 40 | New root table page number |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker can accept a request |
| req_vaddr | input | 48 | Virtual address to translate |
| req_is_store | input | 1 | 1 = store access, 0 = load |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_paddr | output | 52 | Physical address (0 on fault) |
| rsp_fault | output | 2 | 00 none, 01 not present, 10 write-protect |
| rsp_level | output | 2 | Level where the walk ended |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory took the read request |
| mem_req_addr | output | 52 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data present |
| mem_rsp_data | input | 64 | Entry contents |

## Verification
A root register write can coincide with the acceptance of a translation request, and it can also land in the middle of a walk. The bench provokes the first case by raising `cfg_root_we` in the very cycle that `req_valid` meets `req_ready`. It provokes the second by writing a different root two cycles after acceptance. Two tables map the same virtual address to different page numbers, so the returned address shows which root each walk used. The same-cycle write must steer its own walk; the mid-walk write must steer only the next one.

// File: rtl/ptw_pkg.sv
// Shared constants and types for the page table walker.
// Assumes 4 KiB pages, 9-bit indices per level and 8-byte entries.
package ptw_pkg;
    localparam int VA_W   = 48;
    localparam int PA_W   = 52;
    localparam int OFF_W  = 12;
    localparam int IDX_W  = 9;
    localparam int LEVELS = 4;
    localparam int PTE_W  = 64;
    localparam int PPN_W  = PA_W - OFF_W;
    localparam int LVL_W  = $clog2(LEVELS);
    localparam int ENT_SH = $clog2(PTE_W / 8);
    localparam int BIT_PRESENT  = 0;
    localparam int BIT_WRITABLE = 1;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'b00,
        CAUSE_ABSENT = 2'b01,
        CAUSE_WRPROT = 2'b10
    } cause_e;
endpackage

// File: rtl/ptw_entry_addr.sv
// Forms the byte address of the entry used at one walk level.
// Assumes the table base is page aligned, so base and scaled index never overlap.
module ptw_entry_addr
    import ptw_pkg::*;
#(
    parameter int P_VA_W  = VA_W,
    parameter int P_PA_W  = PA_W,
    parameter int P_OFF_W = OFF_W,
    parameter int P_IDX_W = IDX_W,
    parameter int P_LVL_W = LVL_W,
    parameter int P_SH    = ENT_SH,
    localparam int P_PPN_W = P_PA_W - P_OFF_W
) (
    input  logic [P_PPN_W-1:0] tbl_ppn,
    input  logic [P_VA_W-1:0]  vaddr,
    input  logic [P_LVL_W-1:0] level,
    output logic [P_PA_W-1:0]  ent_addr
);
    logic [P_IDX_W-1:0] idx;

    // Pick this level's index field and scale it by the entry size.
    always_comb begin
        idx      = vaddr[P_OFF_W + int'(level) * P_IDX_W +: P_IDX_W];
        ent_addr = {tbl_ppn, {P_OFF_W{1'b0}}}
                 | P_PA_W'({idx, {P_SH{1'b0}}});
    end
endmodule

// File: rtl/ptw_entry_eval.sv
// Decodes one fetched entry: fault cause, next page number, leaf flag.
// Assumes write permission matters only at level 0.
module ptw_entry_eval
    import ptw_pkg::*;
#(
    parameter int P_PTE_W = PTE_W,
    parameter int P_PA_W  = PA_W,
    parameter int P_OFF_W = OFF_W,
    parameter int P_LVL_W = LVL_W,
    localparam int P_PPN_W = P_PA_W - P_OFF_W
) (
    input  logic [P_PTE_W-1:0] pte,
    input  logic [P_LVL_W-1:0] level,
    input  logic               is_store,
    output cause_e             cause,
    output logic [P_PPN_W-1:0] next_ppn,
    output logic               is_leaf
);
    // Classify the entry against the access type and level.
    always_comb begin
        is_leaf  = (level == '0);
        next_ppn = pte[P_PA_W-1:P_OFF_W];
        if (!pte[BIT_PRESENT])
            cause = CAUSE_ABSENT;
        else if (is_leaf && is_store && !pte[BIT_WRITABLE])
            cause = CAUSE_WRPROT;
        else
            cause = CAUSE_NONE;
    end
endmodule

// File: rtl/ptw_walker.sv
// Four-level page table walker. It accepts one translation at a time,
// reads one entry per level and returns an address or a fault.
// Assumes memory answers each accepted read exactly once, in order.
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int P_VA_W  = VA_W,
    parameter int P_PA_W  = PA_W,
    parameter int P_OFF_W = OFF_W,
    parameter int P_PTE_W = PTE_W,
    localparam int P_PPN_W = P_PA_W - P_OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_root_we,
    input  logic [P_PPN_W-1:0] cfg_root_ppn,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [P_VA_W-1:0]  req_vaddr,
    input  logic               req_is_store,
    output logic               rsp_valid,
    output logic [P_PA_W-1:0]  rsp_paddr,
    output logic [1:0]         rsp_fault,
    output logic [LVL_W-1:0]   rsp_level,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [P_PA_W-1:0]  mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [P_PTE_W-1:0] mem_rsp_data
);
    typedef enum logic [1:0] {ST_IDLE, ST_ASK, ST_WAIT, ST_DONE} state_e;

    state_e             state_q;
    logic [P_PPN_W-1:0] root_q, base_q, root_eff, ev_ppn;
    logic [LVL_W-1:0]   lvl_q;
    logic [P_VA_W-1:0]  va_q;
    logic               st_q, ev_leaf, accept;
    logic [P_PA_W-1:0]  paddr_q;
    cause_e             cause_q, ev_cause;

    assign req_ready     = (state_q == ST_IDLE);
    assign accept        = req_valid && req_ready;
    assign root_eff      = cfg_root_we ? cfg_root_ppn : root_q;
    assign mem_req_valid = (state_q == ST_ASK);
    assign rsp_valid     = (state_q == ST_DONE);
    assign rsp_paddr     = paddr_q;
    assign rsp_fault     = cause_q;
    assign rsp_level     = lvl_q;

    ptw_entry_addr #(.P_VA_W(P_VA_W), .P_PA_W(P_PA_W), .P_OFF_W(P_OFF_W)) u_addr (
        .tbl_ppn (base_q),
        .vaddr   (va_q),
        .level   (lvl_q),
        .ent_addr(mem_req_addr)
    );

    ptw_entry_eval #(.P_PTE_W(P_PTE_W), .P_PA_W(P_PA_W), .P_OFF_W(P_OFF_W)) u_eval (
        .pte     (mem_rsp_data),
        .level   (lvl_q),
        .is_store(st_q),
        .cause   (ev_cause),
        .next_ppn(ev_ppn),
        .is_leaf (ev_leaf)
    );

    // Root register: replaced by each configuration write.
    always_ff @(posedge clk) begin
        if (!rst_n)           root_q <= '0;
        else if (cfg_root_we) root_q <= cfg_root_ppn;
    end

    // Walk sequencer: accept, read per level, finish on fault or leaf.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            lvl_q   <= '0;
            va_q    <= '0;
            st_q    <= 1'b0;
            paddr_q <= '0;
            cause_q <= CAUSE_NONE;
        end else begin
            case (state_q)
                ST_IDLE: if (accept) begin
                    base_q  <= root_eff;
                    lvl_q   <= LVL_W'(LEVELS - 1);
                    va_q    <= req_vaddr;
                    st_q    <= req_is_store;
                    paddr_q <= '0;
                    cause_q <= CAUSE_NONE;
                    state_q <= ST_ASK;
                end
                ST_ASK: if (mem_req_ready) state_q <= ST_WAIT;
                ST_WAIT: if (mem_rsp_valid) begin
                    if (ev_cause != CAUSE_NONE) begin
                        cause_q <= ev_cause;
                        paddr_q <= '0;
                        state_q <= ST_DONE;
                    end else if (ev_leaf) begin
                        paddr_q <= {ev_ppn, va_q[P_OFF_W-1:0]};
                        state_q <= ST_DONE;
                    end else begin
                        base_q  <= ev_ppn;
                        lvl_q   <= lvl_q - 1'b1;
                        state_q <= ST_ASK;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // A pending read keeps its request and address until taken.
    assert_mem_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // Results last exactly one cycle.
    assert_rsp_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid && req_ready);

    // No new request is taken while memory traffic is pending.
    assert_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);

    // Entry reads are aligned to the entry size.
    assert_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> mem_req_addr[ENT_SH-1:0] == '0);

    // Write-protect faults arise only at the leaf.
    assert_wp_leaf_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault == CAUSE_WRPROT |-> rsp_level == '0);

    // Success ends at the leaf and keeps the page offset.
    assert_ok_leaf_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault == CAUSE_NONE |->
            rsp_level == '0 && rsp_paddr[P_OFF_W-1:0] == va_q[P_OFF_W-1:0]);
endmodule

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;
    logic clk = 0, rst_n = 0;
    logic cfg_root_we = 0;
    logic [39:0] cfg_root_ppn = '0;
    logic req_valid = 0, req_ready, req_is_store = 0;
    logic [47:0] req_vaddr = '0;
    logic rsp_valid, mem_req_valid, mem_req_ready = 0, mem_rsp_valid = 0;
    logic [51:0] rsp_paddr, mem_req_addr;
    logic [1:0] rsp_fault, rsp_level;
    logic [63:0] mem_rsp_data = '0;

    int n_chk = 0, n_fail = 0;
    logic [63:0] pmem [logic [51:0]];
    logic [51:0] rlog [$];
    logic [39:0] nf = 40'h100;

    always #10 clk = ~clk;

    ptw_walker u_dut (.*);

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [63:0] rd(input logic [51:0] a);
        return pmem.exists(a) ? pmem[a] : 64'h0;
    endfunction

    function automatic logic [51:0] eaddr(input logic [39:0] b, input logic [47:0] va, input int l);
        return {b, 12'h0} | {40'h0, va[12 + 9*l +: 9], 3'b000};
    endfunction

    // Build a mapping, creating missing tables with junk in ignored bits.
    task automatic map(input logic [39:0] root, input logic [47:0] va,
                       input logic [39:0] ppn, input logic wr, input logic pr);
        logic [39:0] b = root;
        for (int l = 3; l >= 1; l--) begin
            logic [51:0] a;
            logic [63:0] e;
            a = eaddr(b, va, l);
            e = rd(a);
            if (!e[0]) begin
                e = {12'($urandom), nf, 10'($urandom), 1'($urandom), 1'b1};
                pmem[a] = e;
                nf++;
            end
            b = e[51:12];
        end
        pmem[eaddr(b, va, 0)] = {12'($urandom), ppn, 10'($urandom), wr, pr};
    endtask

    // Reference walk derived from the requirements.
    function automatic void model(input logic [39:0] root, input logic [47:0] va, input logic st,
                                  output logic [51:0] pa, output logic [1:0] c,
                                  output logic [1:0] lv, output int n, output logic [51:0] ad [4]);
        logic [39:0] b = root;
        pa = '0; c = 2'b00; lv = 2'd0; n = 0;
        for (int i = 0; i < 4; i++) ad[i] = '0;
        for (int l = 3; l >= 0; l--) begin
            logic [63:0] e;
            ad[n] = eaddr(b, va, l);
            e = rd(ad[n]);
            n++;
            lv = 2'(l);
            if (!e[0]) begin c = 2'b01; return; end
            if (l == 0) begin
                if (st && !e[1]) begin c = 2'b10; return; end
                pa = {e[51:12], va[11:0]};
                return;
            end
            b = e[51:12];
        end
    endfunction

    // Memory responder with random request and response latency.
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req_valid) begin
                logic [51:0] a;
                repeat ($urandom % 3) @(negedge clk);
                a = mem_req_addr;
                rlog.push_back(a);
                mem_req_ready = 1;
                @(negedge clk);
                mem_req_ready = 0;
                repeat ($urandom % 4) @(negedge clk);
                mem_rsp_valid = 1;
                mem_rsp_data = rd(a);
                @(negedge clk);
                mem_rsp_valid = 0;
                mem_rsp_data = $urandom;
            end
        end
    end

    task automatic set_root(input logic [39:0] v);
        @(negedge clk);
        cfg_root_we = 1; cfg_root_ppn = v;
        @(negedge clk);
        cfg_root_we = 0;
    endtask

    // One translation; optional root write at acceptance or mid-walk.
    task automatic xlate(input logic [47:0] va, input logic st, input logic we_now,
                         input logic [39:0] v_now, input logic we_mid, input logic [39:0] v_mid,
                         output logic [51:0] pa, output logic [1:0] c, output logic [1:0] lv);
        rlog.delete();
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_vaddr = va; req_is_store = st;
        cfg_root_we = we_now; cfg_root_ppn = v_now;
        @(negedge clk);
        req_valid = 0; cfg_root_we = 0;
        check("R7 ready low while busy", req_ready, 0);
        if (we_mid) begin
            @(negedge clk);
            cfg_root_we = 1; cfg_root_ppn = v_mid;
            @(negedge clk);
            cfg_root_we = 0;
        end
        while (!rsp_valid) @(negedge clk);
        pa = rsp_paddr; c = rsp_fault; lv = rsp_level;
        @(negedge clk);
        check("R7 pulse ends, ready again", {rsp_valid, req_ready}, 2'b01);
    endtask

    // Translate and compare every output and every read against the model.
    task automatic run(input string tag, input logic [39:0] mroot, input logic [47:0] va,
                       input logic st, input logic we_now, input logic [39:0] v_now,
                       input logic we_mid, input logic [39:0] v_mid);
        logic [51:0] pa, epa;
        logic [1:0] c, lv, ec, elv;
        int en;
        logic [51:0] ead [4];
        model(mroot, va, st, epa, ec, elv, en, ead);
        xlate(va, st, we_now, v_now, we_mid, v_mid, pa, c, lv);
        check({tag, " R1/R4 paddr"}, pa, epa);
        check({tag, " R5/R6 fault"}, c, ec);
        check({tag, " R5 level"}, lv, elv);
        check({tag, " R3 read count"}, rlog.size(), en);
        for (int i = 0; i < en && i < rlog.size(); i++)
            check({tag, " R2 entry address"}, rlog[i], ead[i]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [51:0] pa;
        logic [1:0] c, lv;
        logic [47:0] vas [12];
        logic [39:0] rA = 40'h0, rB = 40'h50;
        void'($urandom(32'd2024));

        repeat (3) @(negedge clk);
        check("R10 reset ready", req_ready, 1);
        check("R10 reset rsp_valid", rsp_valid, 0);
        check("R10 reset mem_req_valid", mem_req_valid, 0);
        rst_n = 1;

        // R10: root 0 after reset; R1 R2 R3 R4 full walk.
        map(rA, 48'h0000_0040_2ABC, 40'h3, 1'b1, 1'b1);
        xlate(48'h0000_0040_2ABC, 1'b0, 1'b0, '0, 1'b0, '0, pa, c, lv);
        check("R10 root zero R1 paddr", pa, 52'h3ABC);
        check("R3 four reads", rlog.size(), 4);
        check("R2 root entry address", rlog.size() > 0 ? rlog[0] : '1, 52'h0);
        run("R1 store writable", rA, 48'h0000_0040_2ABC, 1'b1, 1'b0, '0, 1'b0, '0);

        // R6: read-only leaf.
        map(rA, 48'h7FFF_FFFF_F123, 40'hABCDE, 1'b0, 1'b1);
        xlate(48'h7FFF_FFFF_F123, 1'b0, 1'b0, '0, 1'b0, '0, pa, c, lv);
        check("R6 load of read-only page", {c, pa}, {2'b00, 52'hABCDE123});
        xlate(48'h7FFF_FFFF_F123, 1'b1, 1'b0, '0, 1'b0, '0, pa, c, lv);
        check("R6 store write-protect", {c, lv, pa}, {2'b10, 2'd0, 52'h0});

        // R5: faults at root, level 2 and leaf.
        xlate(48'h8000_0000_0000, 1'b0, 1'b0, '0, 1'b0, '0, pa, c, lv);
        check("R5 root absent", {c, lv}, {2'b01, 2'd3});
        check("R5 root absent one read", rlog.size(), 1);
        xlate(48'h0000_7FC0_0000, 1'b1, 1'b0, '0, 1'b0, '0, pa, c, lv);
        check("R5 level-2 absent", {c, lv, pa}, {2'b01, 2'd2, 52'h0});
        check("R5 level-2 two reads", rlog.size(), 2);
        map(rA, 48'h0000_0040_5000, 40'h9, 1'b1, 1'b0);
        xlate(48'h0000_0040_5000, 1'b0, 1'b0, '0, 1'b0, '0, pa, c, lv);
        check("R5 leaf absent", {c, lv}, {2'b01, 2'd0});

        // R8: second root maps the same address elsewhere.
        map(rB, 48'h0000_0040_2ABC, 40'h77, 1'b1, 1'b1);
        set_root(rB);
        xlate(48'h0000_0040_2ABC, 1'b0, 1'b0, '0, 1'b0, '0, pa, c, lv);
        check("R8 switched root", pa, 52'h77ABC);
        xlate(48'h0000_0040_2ABC, 1'b0, 1'b1, rA, 1'b0, '0, pa, c, lv);
        check("R8 same-cycle root write", pa, 52'h3ABC);
        xlate(48'h0000_0040_2ABC, 1'b0, 1'b0, '0, 1'b1, rB, pa, c, lv);
        check("R8 mid-walk write ignored", pa, 52'h3ABC);
        xlate(48'h0000_0040_2ABC, 1'b0, 1'b0, '0, 1'b0, '0, pa, c, lv);
        check("R8 next walk uses new root", pa, 52'h77ABC);

        // Random tables and traffic (R1-R6, R9 via random latency).
        for (int i = 0; i < 12; i++) begin
            vas[i] = {9'($urandom % 2), 9'($urandom % 2), 9'($urandom % 4), 9'($urandom), 12'($urandom)};
            map(($urandom % 2) ? rA : rB, vas[i], 40'($urandom), 1'($urandom), 1'($urandom % 5 != 0));
        end
        for (int k = 0; k < 150; k++) begin
            logic [39:0] r;
            logic [47:0] va;
            r = ($urandom % 2) ? rA : rB;
            va = ($urandom % 10 < 7) ? vas[$urandom % 12]
               : {9'($urandom % 3), 9'($urandom % 2), 9'($urandom % 4), 9'($urandom), 12'($urandom)};
            run("R9 random", r, va, 1'($urandom), 1'b1, r, 1'b0, '0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule